// File: doc/BRIEF.md
# Warm-up Rate Controller for a Shift-Register Cipher Core

This block sets how often a cipher core advances its state. After a start request, the core must run a warm-up (key and IV mixing) phase. During that phase its long combinational feedback loops need more time per step, so the block slows the core's step rate by a factor of two or four. Once the programmed number of slow steps has elapsed, the block raises a run flag and lets the core step on every base clock cycle for keystream output.

The block never multiplexes clocks. It produces one clock-enable, `core_en`, for the core, which shares the base clock with the block. The rate divider is a chain of toggle flip-flops: one stage divides by two, and two stages divide by four. A step counter counts the enabled warm-up steps. Its completion flag passes through one more register before full rate begins. This leaves one idle base cycle at the switch, so the first full-rate step always gets a whole base cycle. The rate only ever moves from slow to fast. A new start is the only way back to slow.

Top module: `warmup_rate_ctrl`

## Requirements
- R1: After reset, and until the first start, `core_en` and `run` are both 0.
- R2: With `div_sel`=0 latched at start (divide by two), `core_en` is high in cycles 2, 4, 6, … after the start edge, counting the cycle right after that edge as cycle 1. It is low in the odd cycles.
- R3: With `div_sel`=1 latched at start (divide by four), `core_en` is high only in cycles 4, 8, 12, … after the start edge.
- R4: With L = `warm_len` latched at start and D the divide factor, exactly L warm-up pulses occur. Cycle D·L+1 has `core_en`=0 and `run`=0. `run` rises in cycle D·L+2.
- R5: Once `run` is 1, `core_en` is 1 in every cycle, and both stay 1 until the next start.
- R6: A start while `run` is 1 clears `run` in the next cycle and begins a fresh warm-up with the newly latched settings.
- R7: A start during warm-up discards the partial count and restarts warm-up from cycle 1 with the newly latched settings.
- R8: A `warm_len` of 0 behaves exactly like a `warm_len` of 1.
- R9: Changes on `div_sel` and `warm_len` in cycles where `start` is 0 have no effect. Both are sampled only on the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base (full-rate) clock shared with the cipher core |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new warm-up; sampled on the rising edge |
| div_sel | input | 1 | Warm-up divide select: 0 = divide by 2, 1 = divide by 4 |
| warm_len | input | CNT_W | Number of slow warm-up steps |
| core_en | output | 1 | Step enable for the cipher core |
| run | output | 1 | High once the core is stepping at full rate |

## Verification
The hardest situation to reach is the handover region. This covers the single dead cycle between the last slow pulse and the first full-rate pulse, and a restart that lands in the middle of a divide period or just after the switch. The stimulus reaches it by issuing new starts at chosen cycle offsets: during a divide-by-four warm-up at a non-aligned cycle, and shortly after `run` has risen. It also toggles the divide and length inputs while the controller is busy, and a zero length sets the handover as early as possible.

// File: rtl/rc_pkg.sv
package rc_pkg;

  // Number of toggle stages needed for the largest divide factor (4 = 2^2).
  localparam int RC_MAX_STAGES = 2;

  // Divide factor for a given select value.
  function automatic int unsigned rc_div_factor(input logic quad);
    return quad ? 32'd4 : 32'd2;
  endfunction

  // True when the step that is being accepted is the last warm-up step.
  // A zero length is handled like a length of one.
  function automatic logic rc_warm_last(input logic [31:0] done_steps,
                                        input logic [31:0] length);
    return (done_steps + 32'd1) >= length;
  endfunction

endpackage

// File: rtl/rc_prescaler.sv
module rc_prescaler #(
  parameter int STAGES = rc_pkg::RC_MAX_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic active,
  input  logic quad,
  output logic tick
);

  logic [STAGES-1:0] phase;
  logic [STAGES:0]   carry;

  assign carry[0] = active;

  // Ripple of toggle flops: each stage flips when all lower stages are 1.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign carry[i+1] = carry[i] & phase[i];
    always_ff @(posedge clk) begin
      if (!rst_n)          phase[i] <= 1'b0;
      else if (clear)      phase[i] <= 1'b0;
      else if (carry[i])   phase[i] <= ~phase[i];
    end
  end

  // One stage for divide by two, the full chain for divide by four.
  assign tick = quad ? carry[STAGES] : carry[1];

  // Slow pulses are never back to back (R2, R3).
  assert_tick_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/rc_warm_counter.sv
module rc_warm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] length,
  output logic             warm_done
);

  logic [CNT_W-1:0] steps;
  logic             last_step;

  assign last_step = rc_pkg::rc_warm_last(32'(steps), 32'(length));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      steps     <= '0;
      warm_done <= 1'b0;
    end else if (tick && !warm_done) begin
      if (last_step) warm_done <= 1'b1;
      else           steps     <= steps + 1'b1;
    end
  end

  // The step count never passes the programmed length (R4, R8).
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (steps == '0) || (steps < length));

endmodule

// File: rtl/rc_run_sync.sv
module rc_run_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic done_in,
  output logic run_q
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) run_q <= 1'b0;
    else                 run_q <= done_in;
  end

  // The full-rate flag is never ahead of the counter's completion (R4).
  assert_run_follows_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> done_in);

endmodule

// File: rtl/warmup_rate_ctrl.sv
module warmup_rate_ctrl #(
  parameter int CNT_W  = 16,
  parameter int STAGES = rc_pkg::RC_MAX_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             div_sel,
  input  logic [CNT_W-1:0] warm_len,
  output logic             core_en,
  output logic             run
);

  logic             started;
  logic             quad_q;
  logic [CNT_W-1:0] len_q;
  logic             warm_done;
  logic             warm_active;
  logic             slow_tick;

  // Settings are captured only on a start edge (R9).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      quad_q  <= 1'b0;
      len_q   <= '0;
    end else if (start) begin
      started <= 1'b1;
      quad_q  <= div_sel;
      len_q   <= warm_len;
    end
  end

  assign warm_active = started && !warm_done;

  rc_prescaler #(.STAGES(STAGES)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start),
    .active (warm_active),
    .quad   (quad_q),
    .tick   (slow_tick)
  );

  rc_warm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .tick      (slow_tick),
    .length    (len_q),
    .warm_done (warm_done)
  );

  rc_run_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .done_in (warm_done),
    .run_q   (run)
  );

  assign core_en = run | slow_tick;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (!core_en && !run));

  assert_warm_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && !run) |=> !core_en);

  assert_dead_cycle_before_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> !$past(core_en));

  assert_run_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |=> (run && core_en));

  assert_restart_drops_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !run);

endmodule

// File: tb/warmup_rate_ctrl_test.sv
module warmup_rate_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic             div_sel;
  logic [CNT_W-1:0] warm_len;
  logic             core_en;
  logic             run;

  warmup_rate_ctrl #(.CNT_W(CNT_W)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .div_sel  (div_sel),
    .warm_len (warm_len),
    .core_en  (core_en),
    .run      (run)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0] exp_q[$];
  string      tag_q[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         finished = 1'b0;

  // Driver: drive inputs for the next edge, queue the outputs expected after it.
  task automatic step(input logic s, input logic d, input logic [CNT_W-1:0] l,
                      input logic e_en, input logic e_run, input string tag);
    @(negedge clk);
    start    = s;
    div_sel  = d;
    warm_len = l;
    exp_q.push_back({e_en, e_run});
    tag_q.push_back(tag);
  endtask

  // One warm-up from its start edge, observed for ncyc cycles after it.
  task automatic warm_seq(input logic d, input int l, input int ncyc,
                          input string first_tag, input bit wiggle);
    int    dv = d ? 4 : 2;
    int    le = (l == 0) ? 1 : l;
    step(1'b1, d, CNT_W'(l), 1'b0, 1'b0, first_tag);
    for (int c = 2; c <= ncyc; c++) begin
      logic  en_e, run_e;
      string tg;
      if (c <= dv*le) begin
        en_e = (c % dv) == 0; run_e = 1'b0; tg = d ? "R3" : "R2";
      end else if (c == dv*le + 1) begin
        en_e = 1'b0; run_e = 1'b0; tg = "R4";
      end else begin
        en_e = 1'b1; run_e = 1'b1; tg = (c == dv*le + 2) ? "R4" : "R5";
      end
      if (wiggle) step(1'b0, ~d, CNT_W'(l + 3), en_e, run_e, "R9");
      else        step(1'b0, d, CNT_W'(l), en_e, run_e, tg);
    end
  endtask

  // Monitor: compare each queued expectation a quarter period after the edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if ({core_en, run} !== e) begin
        n_bad++;
        $display("FAIL %s: core_en,run actual %b%b expected %b%b at %0t",
                 t, core_en, run, e[1], e[0], $time);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1: watchdog actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; div_sel = 1'b0; warm_len = '0;
    // R1: reset state, then idle without a start
    repeat (3) step(1'b0, 1'b0, '0, 1'b0, 1'b0, "R1");
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b1, CNT_W'(7), 1'b0, 1'b0, "R1");
    // R2/R4/R5: divide by two, length 5
    warm_seq(1'b0, 5, 16, "R2", 1'b0);
    // R6: restart while running, divide by four, length 3
    warm_seq(1'b1, 3, 17, "R6", 1'b0);
    // R3 then R7: divide by four aborted at a non-aligned cycle
    warm_seq(1'b1, 6, 9, "R3", 1'b0);
    warm_seq(1'b0, 4, 13, "R7", 1'b0);
    // R8: zero length behaves as one
    warm_seq(1'b0, 0, 7, "R8", 1'b0);
    // R9: input changes while busy are ignored
    warm_seq(1'b1, 4, 21, "R9", 1'b1);
    // R4: full warm-up length of the long variant
    warm_seq(1'b1, 160, 645, "R4", 1'b0);
    // R6: restart shortly after the switch
    warm_seq(1'b0, 2, 8, "R6", 1'b0);
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/2);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule